// File: doc/BRIEF.md
# Double-Error Complement Recovery Read Sequencer

This block is a read-control state machine. It sits between a processor port, a memory array and an external error-correcting engine. On each processor request it strobes a memory read for a fixed number of cycles and waits a fixed number of check cycles for the engine's error flags. It then returns either the unchanged word or the corrected word. The engine's arithmetic is outside this block. The block only drives the engine's operating mode and reads its flags and its corrected data.

Two read styles can be chosen. In the monitoring style, the raw word is handed to the processor on an early strobe as soon as the memory phase ends. An interrupt pulse follows if the check finds anything wrong, and the cycle is stretched until the corrected word arrives. In the checked style, the processor only sees the final, checked word, so every read takes the same time.

When the flags report a two-bit error, the block tries to recover a fault made of one stuck cell and one soft flip. First it turns off the memory's output drivers and has the engine write the inverted data and check bits back to the same, held address. This overwrites the soft cell. Then it re-reads that address with the engine set to invert again. Only the soft position is still wrong after the re-read, so it can be corrected as a single error. If the re-read still looks like a two-bit error, or the flags form an invalid pattern, the cycle ends with an uncorrectable indication.

Top module: `ecc_rcv_seq`

## Requirements
- R1: After reset the block is idle with `cpu_rdy`, `cpu_early`, `cpu_irq`, `cpu_uerr`, `mem_rd` and `mem_wr` low, `mem_oe` high and `ecc_mode` = 2'b00 (normal).
- R2: A request seen while idle is accepted on that clock edge. `mem_rd` is high for exactly P_ACC cycles, starting the cycle after acceptance, with `ecc_mode` = 2'b00. The raw word on `mem_q` is taken on the last of those cycles.
- R3: With no recovery, `cpu_rdy` is a one-cycle pulse P_ACC+P_CHK cycles after acceptance. When it is high, `cpu_data` is the word on `ecc_q`.
- R4: In monitoring style (`mode_chk`=0), `cpu_early` pulses for one cycle P_ACC cycles after acceptance and carries the raw word. `cpu_irq` pulses P_ACC+P_CHK cycles after acceptance if the first check's class is anything other than no-error. In checked style neither output ever pulses.
- R5: The flags {`err_any`,`err_single`,`err_data`} are decoded as follows: 000 means no error, 110 means a check-bit single error, 111 means a data single error, 100 means a two-bit error, and every other pattern is invalid. Both single classes are returned as corrected data without recovery.
- R6: A two-bit class on the first check starts a write-back phase of P_ACC cycles. During it `mem_wr` is high, `mem_oe` is low and `ecc_mode` = 2'b01 (invert on write).
- R7: The write-back is followed at once by P_ACC cycles of `mem_rd` and then P_CHK check cycles, all with `ecc_mode` = 2'b10 (invert on read). `cpu_rdy` stays low until it pulses 3·P_ACC+2·P_CHK cycles after acceptance with `cpu_data` = `ecc_q`.
- R8: If the check after the re-read reports a two-bit or invalid class, the final `cpu_rdy` pulse comes with `cpu_uerr` high and `cpu_data` = 0.
- R9: An invalid class on the first check ends the cycle at the normal latency with `cpu_uerr` high, `cpu_data` = 0 and no write-back.
- R10: `mem_addr` takes `cpu_addr` at acceptance and holds it until the cycle ends, whatever `cpu_addr` does meanwhile.
- R11: `mode_chk` and `cpu_req` are sampled only while idle. A mode change mid-cycle does not alter that cycle's early or interrupt behaviour, and a request held high gives a single `cpu_rdy` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_chk | input | 1 | 1 = checked style, 0 = monitoring style |
| cpu_req | input | 1 | Processor read request |
| cpu_addr | input | AW | Processor read address |
| cpu_rdy | output | 1 | Final data valid, one-cycle pulse |
| cpu_early | output | 1 | Raw data valid (monitoring style), one-cycle pulse |
| cpu_data | output | DW | Word returned to the processor |
| cpu_irq | output | 1 | Error interrupt pulse (monitoring style) |
| cpu_uerr | output | 1 | Uncorrectable error, high with the final `cpu_rdy` |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe (write-back phase) |
| mem_oe | output | 1 | Memory data driver enable |
| mem_addr | output | AW | Held memory address |
| mem_q | input | DW | Raw word from memory |
| ecc_mode | output | 2 | Engine mode: 00 normal, 01 invert on write, 10 invert on read |
| err_any | input | 1 | Engine flag: some error found |
| err_single | input | 1 | Engine flag: single-error class |
| err_data | input | 1 | Engine flag: error lies in the data field |
| ecc_q | input | DW | Corrected word from the engine |

## Verification
The assertions assume three things. The memory and the engine present valid data and flags on the cycles the sequencer samples them. The engine's flags follow the mode the sequencer drives. Reset is held for at least two clocks before the first request. The bench keeps to this: it models memory and engine from the sequencer's own outputs, returning the raw word only while `mem_rd` is high and switching to the re-read flags and corrected word only while `ecc_mode` is 2'b10. It also changes `cpu_addr` and `mode_chk` only in the middle of a busy cycle or while idle, away from the active edge.

// File: rtl/ecc_rcv_pkg.sv
package ecc_rcv_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD,
    S_CHK,
    S_IWR,
    S_IRD,
    S_ICHK
  } seq_st_t;

  typedef enum logic [1:0] {
    EM_NORMAL = 2'b00,
    EM_INV_WR = 2'b01,
    EM_INV_RD = 2'b10
  } ecc_md_t;

  typedef enum logic [2:0] {
    FC_NONE,
    FC_CHKBIT,
    FC_DATABIT,
    FC_DOUBLE,
    FC_BAD
  } flag_cls_t;

endpackage

// File: rtl/ecc_rcv_flagdec.sv
module ecc_rcv_flagdec
  import ecc_rcv_pkg::*;
(
  input  logic      err_any,
  input  logic      err_single,
  input  logic      err_data,
  output flag_cls_t cls
);

  always_comb begin
    case ({err_any, err_single, err_data})
      3'b000:  cls = FC_NONE;
      3'b110:  cls = FC_CHKBIT;
      3'b111:  cls = FC_DATABIT;
      3'b100:  cls = FC_DOUBLE;
      default: cls = FC_BAD;
    endcase
  end

endmodule

// File: rtl/ecc_rcv_phase_cnt.sv
module ecc_rcv_phase_cnt #(
  parameter int MAXV = 2,
  parameter int CW   = $clog2(MAXV + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - CW'(1);
    end
  end

  assign zero = (cnt == '0);

  // R2: a phase never runs longer than its longest configured length
  a_r2_cnt_range: assert property (@(posedge clk) disable iff (rst)
    int'(cnt) <= MAXV);

  // R2: once loaded with a nonzero count the counter moves towards zero
  a_r2_cnt_moves: assert property (@(posedge clk) disable iff (rst)
    (!load && !zero) |=> (int'(cnt) == int'($past(cnt)) - 1));

endmodule

// File: rtl/ecc_rcv_addr_hold.sv
module ecc_rcv_addr_hold #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap,
  input  logic [AW-1:0] d,
  output logic [AW-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (cap) begin
      q <= d;
    end
  end

endmodule

// File: rtl/ecc_rcv_seq.sv
module ecc_rcv_seq
  import ecc_rcv_pkg::*;
#(
  parameter int AW    = 12,
  parameter int DW    = 16,
  parameter int P_ACC = 3,
  parameter int P_CHK = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_chk,
  input  logic          cpu_req,
  input  logic [AW-1:0] cpu_addr,
  output logic          cpu_rdy,
  output logic          cpu_early,
  output logic [DW-1:0] cpu_data,
  output logic          cpu_irq,
  output logic          cpu_uerr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          mem_oe,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_q,
  output logic [1:0]    ecc_mode,
  input  logic          err_any,
  input  logic          err_single,
  input  logic          err_data,
  input  logic [DW-1:0] ecc_q
);

  localparam int MAXP = ((P_ACC > P_CHK) ? P_ACC : P_CHK) - 1;
  localparam int CW   = $clog2(MAXP + 2);
  localparam logic [CW-1:0] LD_ACC = CW'(P_ACC - 1);
  localparam logic [CW-1:0] LD_CHK = CW'(P_CHK - 1);

  seq_st_t       st;
  flag_cls_t     cls;
  ecc_md_t       md;
  logic          mon_q;
  logic          cnt_ld;
  logic [CW-1:0] cnt_val;
  logic          cnt_zero;
  logic          accept;

  assign accept = (st == S_IDLE) && cpu_req;

  ecc_rcv_flagdec u_dec (
    .err_any    (err_any),
    .err_single (err_single),
    .err_data   (err_data),
    .cls        (cls)
  );

  ecc_rcv_phase_cnt #(.MAXV(MAXP), .CW(CW)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (cnt_ld),
    .load_val (cnt_val),
    .zero     (cnt_zero)
  );

  ecc_rcv_addr_hold #(.AW(AW)) u_addr (
    .clk (clk),
    .rst (rst),
    .cap (accept),
    .d   (cpu_addr),
    .q   (mem_addr)
  );

  // phase length selection on each state transition
  always_comb begin
    cnt_ld  = 1'b0;
    cnt_val = '0;
    case (st)
      S_IDLE: if (cpu_req) begin
        cnt_ld  = 1'b1;
        cnt_val = LD_ACC;
      end
      S_RD: if (cnt_zero) begin
        cnt_ld  = 1'b1;
        cnt_val = LD_CHK;
      end
      S_CHK: if (cnt_zero && cls == FC_DOUBLE) begin
        cnt_ld  = 1'b1;
        cnt_val = LD_ACC;
      end
      S_IWR: if (cnt_zero) begin
        cnt_ld  = 1'b1;
        cnt_val = LD_ACC;
      end
      S_IRD: if (cnt_zero) begin
        cnt_ld  = 1'b1;
        cnt_val = LD_CHK;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      mon_q     <= 1'b0;
      cpu_rdy   <= 1'b0;
      cpu_early <= 1'b0;
      cpu_irq   <= 1'b0;
      cpu_uerr  <= 1'b0;
      cpu_data  <= '0;
    end else begin
      cpu_rdy   <= 1'b0;
      cpu_early <= 1'b0;
      cpu_irq   <= 1'b0;
      cpu_uerr  <= 1'b0;
      case (st)
        S_IDLE: begin
          if (cpu_req) begin
            st    <= S_RD;
            mon_q <= ~mode_chk;
          end
        end
        S_RD: begin
          if (cnt_zero) begin
            st        <= S_CHK;
            cpu_data  <= mem_q;
            cpu_early <= mon_q;
          end
        end
        S_CHK: begin
          if (cnt_zero) begin
            cpu_irq <= mon_q && (cls != FC_NONE);
            case (cls)
              FC_DOUBLE: st <= S_IWR;
              FC_BAD: begin
                st       <= S_IDLE;
                cpu_rdy  <= 1'b1;
                cpu_uerr <= 1'b1;
                cpu_data <= '0;
              end
              default: begin
                st       <= S_IDLE;
                cpu_rdy  <= 1'b1;
                cpu_data <= ecc_q;
              end
            endcase
          end
        end
        S_IWR: if (cnt_zero) st <= S_IRD;
        S_IRD: if (cnt_zero) st <= S_ICHK;
        S_ICHK: begin
          if (cnt_zero) begin
            st      <= S_IDLE;
            cpu_rdy <= 1'b1;
            if (cls == FC_DOUBLE || cls == FC_BAD) begin
              cpu_uerr <= 1'b1;
              cpu_data <= '0;
            end else begin
              cpu_data <= ecc_q;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    if (st == S_IWR)
      md = EM_INV_WR;
    else if (st == S_IRD || st == S_ICHK)
      md = EM_INV_RD;
    else
      md = EM_NORMAL;
  end

  assign ecc_mode = md;
  assign mem_rd   = (st == S_RD) || (st == S_IRD);
  assign mem_wr   = (st == S_IWR);
  assign mem_oe   = (st != S_IWR);

  // R6: memory drivers are off whenever the write-back strobe is high
  a_r6_wr_no_oe: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> (!mem_oe && ecc_mode == EM_INV_WR));

  // R7: the write-back is followed directly by an inverted re-read
  a_r7_rerd_follows: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_wr) |-> (mem_rd && ecc_mode == EM_INV_RD));

  // R3: the ready strobe lasts a single cycle
  a_r3_rdy_pulse: assert property (@(posedge clk) disable iff (rst)
    cpu_rdy |=> !cpu_rdy);

  // R8: uncorrectable is only reported together with ready
  a_r8_uerr_with_rdy: assert property (@(posedge clk) disable iff (rst)
    cpu_uerr |-> cpu_rdy);

  // R10: address held while a cycle is in progress
  a_r10_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (st != S_IDLE && $past(st) != S_IDLE) |-> $stable(mem_addr));

  // R2: read and write strobes never overlap, and no ready during a read
  a_r2_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr) && !(mem_rd && cpu_rdy));

  // R4: early strobe only in monitoring style
  a_r4_early_mon: assert property (@(posedge clk) disable iff (rst)
    cpu_early |-> mon_q);

endmodule

// File: tb/sim_ecc_rcv_seq.sv
module sim_ecc_rcv_seq;

  localparam int AW = 12;
  localparam int DW = 16;
  localparam int A  = 3;
  localparam int C  = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mode_chk = 1'b1;
  logic          cpu_req = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic          cpu_rdy, cpu_early, cpu_irq, cpu_uerr;
  logic [DW-1:0] cpu_data;
  logic          mem_rd, mem_wr, mem_oe;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_q;
  logic [1:0]    ecc_mode;
  logic          err_any, err_single, err_data;
  logic [DW-1:0] ecc_q;

  // behavioural memory and engine stand-ins
  logic [DW-1:0] raw_w = '0, c1_w = '0, c2_w = '0;
  logic [2:0]    f1_w = '0, f2_w = '0;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  always_comb begin
    mem_q = mem_rd ? raw_w : '0;
    {err_any, err_single, err_data} = (ecc_mode == 2'b10) ? f2_w : f1_w;
    ecc_q = (ecc_mode == 2'b10) ? c2_w : c1_w;
  end

  ecc_rcv_seq #(.AW(AW), .DW(DW), .P_ACC(A), .P_CHK(C)) u0 (
    .clk(clk), .rst(rst), .mode_chk(mode_chk), .cpu_req(cpu_req),
    .cpu_addr(cpu_addr), .cpu_rdy(cpu_rdy), .cpu_early(cpu_early),
    .cpu_data(cpu_data), .cpu_irq(cpu_irq), .cpu_uerr(cpu_uerr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_oe(mem_oe), .mem_addr(mem_addr),
    .mem_q(mem_q), .ecc_mode(ecc_mode), .err_any(err_any),
    .err_single(err_single), .err_data(err_data), .ecc_q(ecc_q)
  );

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // class: 0 none, 1 single, 2 double, 3 invalid (R5 encoding)
  function automatic int fcls(input logic [2:0] f);
    case (f)
      3'b000:          return 0;
      3'b110, 3'b111:  return 1;
      3'b100:          return 2;
      default:         return 3;
    endcase
  endfunction

  task automatic idle_chk(input string tag);
    chk(tag, "idle rdy", cpu_rdy, 0);
    chk(tag, "idle early", cpu_early, 0);
    chk(tag, "idle irq", cpu_irq, 0);
    chk(tag, "idle uerr", cpu_uerr, 0);
    chk(tag, "idle mem_rd", mem_rd, 0);
    chk(tag, "idle mem_wr", mem_wr, 0);
    chk(tag, "idle mem_oe", mem_oe, 1);
    chk(tag, "idle ecc_mode", ecc_mode, 0);
  endtask

  task automatic txn(input bit mon, input logic [AW-1:0] a,
                     input logic [DW-1:0] raw, input logic [DW-1:0] c1,
                     input logic [2:0] f1, input logic [DW-1:0] c2,
                     input logic [2:0] f2);
    int c1k, c2k, fin;
    bit rec, uerr;
    logic [DW-1:0] dexp;
    c1k  = fcls(f1);
    c2k  = fcls(f2);
    rec  = (c1k == 2);
    fin  = rec ? (3*A + 2*C) : (A + C);
    uerr = (c1k == 3) || (rec && c2k >= 2);
    dexp = uerr ? '0 : (rec ? c2 : c1);
    @(negedge clk);
    raw_w = raw; c1_w = c1; c2_w = c2; f1_w = f1; f2_w = f2;
    mode_chk = ~mon;
    cpu_addr = a;
    cpu_req  = 1'b1;
    for (int k = 0; k <= fin; k++) begin
      bit rd_e, wr_e, rerd;
      int em_e;
      @(negedge clk);
      rerd = rec && (k >= 2*A + C) && (k < fin);
      rd_e = (k < A) || (rec && k >= 2*A + C && k < 3*A + C);
      wr_e = rec && (k >= A + C) && (k < 2*A + C);
      em_e = wr_e ? 1 : (rerd ? 2 : 0);
      chk(rec ? "R7" : "R2", "mem_rd", mem_rd, rd_e);
      chk("R6", "mem_wr", mem_wr, wr_e);
      chk("R6", "mem_oe", mem_oe, !wr_e);
      chk(rec ? "R6/R7" : "R2", "ecc_mode", ecc_mode, em_e);
      chk("R10", "mem_addr", mem_addr, a);
      chk("R4/R11", "early", cpu_early, mon && k == A);
      chk("R4/R11", "irq", cpu_irq, mon && k == A + C && c1k != 0);
      chk(rec ? "R7" : "R3", "rdy", cpu_rdy, k == fin);
      chk(rec ? "R8" : "R9", "uerr", cpu_uerr, (k == fin) && uerr);
      if (mon && k == A) chk("R4", "early data", cpu_data, raw);
      if (k == fin) chk("R3/R5", "final data", cpu_data, dexp);
      if (k == 1) begin
        cpu_addr = ~a;          // R10 stimulus
        mode_chk = mon;         // R11 stimulus: flipped mid-cycle
      end
      if (k == fin) cpu_req = 1'b0;
    end
    @(negedge clk);
    idle_chk("R11");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    idle_chk("R1");
    // checked style, clean word
    txn(0, 12'h123, 16'hA5A5, 16'hA5A5, 3'b000, 16'h0, 3'b000);
    // checked style, data single corrected
    txn(0, 12'h0F0, 16'h1235, 16'h1234, 3'b111, 16'h0, 3'b000);
    // monitoring, clean
    txn(1, 12'h200, 16'h00FF, 16'h00FF, 3'b000, 16'h0, 3'b000);
    // monitoring, check-bit single
    txn(1, 12'h3C3, 16'h7777, 16'h7777, 3'b110, 16'h0, 3'b000);
    // checked, double recovered as data single
    txn(0, 12'h444, 16'hFFFF, 16'h0000, 3'b100, 16'hBEEF, 3'b111);
    // monitoring, double recovered as check-bit single
    txn(1, 12'h555, 16'h1111, 16'h2222, 3'b100, 16'hCAFE, 3'b110);
    // double then double again: uncorrectable
    txn(0, 12'h666, 16'h3333, 16'h4444, 3'b100, 16'h5555, 3'b100);
    // double then invalid pattern
    txn(1, 12'h777, 16'h6666, 16'h7777, 3'b100, 16'h8888, 3'b101);
    // invalid on first check, monitoring
    txn(1, 12'h888, 16'h9999, 16'hAAAA, 3'b010, 16'h0, 3'b000);
    // invalid on first check, checked style
    txn(0, 12'h999, 16'hBBBB, 16'hCCCC, 3'b011, 16'h0, 3'b000);
    // double then clean re-read
    txn(0, 12'hABC, 16'hDDDD, 16'hEEEE, 3'b100, 16'h1357, 3'b000);
    // back-to-back edge values
    txn(1, 12'hFFF, 16'hFFFF, 16'hFFFF, 3'b000, 16'h0, 3'b000);
    txn(0, 12'h000, 16'h0000, 16'h8000, 3'b111, 16'h0, 3'b000);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule